// File: doc/BRIEF.md
# Dual Slave Address Matcher

This block decides whether a two-wire serial bus slave answers the address phase of a transfer. A bit-level front end handles the data and clock lines. It passes this block a pulse for each start or repeated start, a pulse for each stop, and each received byte together with a one-cycle valid strobe. The block compares the address byte or bytes against two own-address slots and reports its decision one cycle after the byte strobe. The decision carries an acknowledge bit, a held hit flag, a one-hot code naming the slot that matched, and the direction bit taken from the first byte.

Slot 1 holds either a 7-bit address or a 10-bit address. A 10-bit address is received as a header byte `11110 a9 a8 rw` followed by a byte carrying `a7..a0`. Slot 2 holds a 7-bit address. A 2-bit mask field selects how many of its low address bits are treated as always equal. Both slots can be enabled together.

When the host is asleep, the block also drives a low-power path. A start raises a request for the internal clock, and SCL is held low until that clock reports ready. A final match raises a wake request and keeps SCL stretched until the host reports that it is awake. A mismatch drops the clock request and raises no wake request.

Top module: `dual_addr_matcher`

## Requirements
- R1: With slot 1 enabled in 7-bit mode, a first byte whose bits 7:1 equal the slot address gives a decision with ack=1, hit=1 and slot code 01 (bit 0 = slot 1, bit 1 = slot 2). The direction output equals bit 0 of that byte.
- R2: Slot 2 matches when bits 7:1 of the byte equal its address in every position except the low N bits, where N (0 to 3) is the mask code. On a match the slot code is 10. A difference in an unmasked bit gives no match.
- R3: A byte that matches no enabled slot gives a decision with ack=0, hit=0 and slot code 00. A disabled slot never matches.
- R4: With both slots enabled, a match on either slot gives ack=1. When both match, the slot code is 01.
- R5: In 10-bit mode, a first byte `11110 a9 a8 0` is acknowledged with hit=0. If the next byte equals a7..a0, the decision is ack=1, hit=1, slot code 01 and direction 0. Any other second byte gives ack=0.
- R6: After a successful 10-bit write match, a repeated start followed by `11110 a9 a8 1` is acknowledged as a match with hit=1, slot code 01 and direction 1. The same read header after a stop, with no fresh 10-bit match, is refused.
- R7: A decision strobe appears exactly one cycle after each address byte strobe. Bytes after a completed match, or after a refusal, give no decision and leave the outputs unchanged until the next start.
- R8: When low power and stretching are both enabled, the clock request rises the cycle after a start. SCL hold is high while the clock request is high and clock ready is low.
- R9: A final match in low power raises the wake request the cycle after the decisive byte, and SCL hold stays high. One cycle after host awake is seen, the wake request, the clock request and SCL hold are all low.
- R10: A refusal in low power raises no wake request, drops the clock request the cycle after the byte, and gives ack=0.
- R11: With stretching disabled, low-power mode raises neither the clock request nor the wake request.
- R12: A stop or a start clears the hit flag and the slot code in the cycle after its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start_i | input | 1 | Start or repeated start pulse |
| ev_stop_i | input | 1 | Stop condition pulse |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte, bit 0 is the direction bit of a header |
| s1_en_i | input | 1 | Slot 1 enable |
| s1_wide_i | input | 1 | Slot 1 holds a 10-bit address |
| s1_addr_i | input | 10 | Slot 1 address, bits 6:0 used in 7-bit mode |
| s2_en_i | input | 1 | Slot 2 enable |
| s2_addr_i | input | 7 | Slot 2 address |
| s2_mask_i | input | 2 | Number of slot 2 low bits ignored |
| lp_mode_i | input | 1 | Host is asleep |
| stretch_en_i | input | 1 | Clock stretching allowed |
| clk_ready_i | input | 1 | Internal clock is running |
| host_awake_i | input | 1 | Host confirms it is awake |
| dec_vld_o | output | 1 | Decision strobe |
| dec_ack_o | output | 1 | Acknowledge for the decided byte |
| hit_o | output | 1 | Address fully matched, held until stop or start |
| slot_o | output | 2 | One-hot matched slot |
| dir_rd_o | output | 1 | Direction bit, 1 = read |
| clk_req_o | output | 1 | Internal clock request |
| wake_req_o | output | 1 | Wake request to the host |
| scl_hold_o | output | 1 | Hold SCL low |

## Verification
A wrong phase state shows up at the next byte strobe. A missing or extra decision strobe appears one cycle later, and a 10-bit second byte is then compared against the wrong pattern. A stale 10-bit success flag shows as a read header being accepted after a stop, at the very next decision. Errors in the low-power register pair show one cycle after a start, a decision or host awake, as a wrong clock request, wake request or SCL hold level.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SHORT_W  = 7;
  localparam int unsigned WIDE_W   = 10;
  localparam int unsigned MASK_W   = 2;
  localparam int unsigned SLOT_CNT = 2;
  localparam logic [4:0]  HDR_TAG  = 5'b11110;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HDR,
    PH_LOW,
    PH_DATA
  } phase_e;

  typedef logic [SLOT_CNT-1:0] slot_t;
endpackage

// File: rtl/addr_cmp.sv
module addr_cmp
  import addr_match_pkg::*;
(
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic [WIDE_W-1:0]  s1_addr_i,
  input  logic               s1_wide_i,
  input  logic [SHORT_W-1:0] s2_addr_i,
  input  logic [MASK_W-1:0]  s2_mask_i,
  output logic               s1_short_o,
  output logic               s1_hdr_o,
  output logic               s1_low_o,
  output logic               s2_o
);
  logic [SHORT_W-1:0] keep;
  logic [SHORT_W-1:0] diff;

  always_comb begin
    keep       = {SHORT_W{1'b1}} << s2_mask_i;
    diff       = byte_i[BYTE_W-1:1] ^ s2_addr_i;
    s1_short_o = !s1_wide_i && (byte_i[BYTE_W-1:1] == s1_addr_i[SHORT_W-1:0]);
    s1_hdr_o   = s1_wide_i && (byte_i[BYTE_W-1:1] == {HDR_TAG, s1_addr_i[WIDE_W-1:BYTE_W]});
    s1_low_o   = s1_wide_i && (byte_i == s1_addr_i[BYTE_W-1:0]);
    s2_o       = ((diff & keep) == '0);
  end
endmodule

// File: rtl/wake_ctl.sv
module wake_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_active_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic match_i,
  input  logic nack_i,
  input  logic clk_ready_i,
  input  logic host_awake_i,
  output logic clk_req_o,
  output logic wake_req_o,
  output logic scl_hold_o
);
  logic clk_req_q, clk_req_d;
  logic wake_q, wake_d;

  always_comb begin
    clk_req_d = clk_req_q;
    wake_d    = wake_q;
    if (start_i && lp_active_i) begin
      clk_req_d = 1'b1;
    end else if (nack_i || (stop_i && !wake_q)) begin
      clk_req_d = 1'b0;
    end else if (wake_q && host_awake_i) begin
      clk_req_d = 1'b0;
    end
    if (match_i && lp_active_i) begin
      wake_d = 1'b1;
    end else if (host_awake_i) begin
      wake_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_req_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      clk_req_q <= clk_req_d;
      wake_q    <= wake_d;
    end
  end

  assign clk_req_o  = clk_req_q;
  assign wake_req_o = wake_q;
  assign scl_hold_o = wake_q || (clk_req_q && !clk_ready_i);

  p_start_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && lp_active_i |=> clk_req_q);
  p_hold_till_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q && !host_awake_i |=> wake_q);
  p_nack_drops_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nack_i && !start_i |=> !clk_req_q && !wake_q);
  p_wake_needs_stretch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_q) |-> $past(lp_active_i));
endmodule

// File: rtl/dual_addr_matcher.sv
module dual_addr_matcher
  import addr_match_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_start_i,
  input  logic               ev_stop_i,
  input  logic               byte_vld_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic               s1_en_i,
  input  logic               s1_wide_i,
  input  logic [WIDE_W-1:0]  s1_addr_i,
  input  logic               s2_en_i,
  input  logic [SHORT_W-1:0] s2_addr_i,
  input  logic [MASK_W-1:0]  s2_mask_i,
  input  logic               lp_mode_i,
  input  logic               stretch_en_i,
  input  logic               clk_ready_i,
  input  logic               host_awake_i,
  output logic               dec_vld_o,
  output logic               dec_ack_o,
  output logic               hit_o,
  output logic [SLOT_CNT-1:0] slot_o,
  output logic               dir_rd_o,
  output logic               clk_req_o,
  output logic               wake_req_o,
  output logic               scl_hold_o
);
  localparam slot_t SLOT_ONE = slot_t'(1);
  localparam slot_t SLOT_TWO = slot_t'(2);

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic s1_short, s1_hdr, s1_low, s2_eq;

  addr_cmp u_cmp (
    .byte_i     (byte_i),
    .s1_addr_i  (s1_addr_i),
    .s1_wide_i  (s1_wide_i),
    .s2_addr_i  (s2_addr_i),
    .s2_mask_i  (s2_mask_i),
    .s1_short_o (s1_short),
    .s1_hdr_o   (s1_hdr),
    .s1_low_o   (s1_low),
    .s2_o       (s2_eq)
  );

  phase_e phase_q, phase_d;
  logic   tenbit_q, tenbit_d;
  logic   vld_q, vld_d;
  logic   ack_q, ack_d;
  slot_t  slot_q, slot_d;
  logic   dir_q, dir_d;
  logic   fin_match, fin_nack;

  always_comb begin
    phase_d   = phase_q;
    tenbit_d  = tenbit_q;
    vld_d     = 1'b0;
    ack_d     = ack_q;
    slot_d    = slot_q;
    dir_d     = dir_q;
    fin_match = 1'b0;
    fin_nack  = 1'b0;
    if (ev_stop_i) begin
      phase_d  = PH_IDLE;
      tenbit_d = 1'b0;
      slot_d   = '0;
    end else if (ev_start_i) begin
      phase_d = PH_HDR;
      slot_d  = '0;
    end else if (byte_vld_i) begin
      unique case (phase_q)
        PH_HDR: begin
          vld_d = 1'b1;
          dir_d = byte_i[0];
          ack_d = 1'b1;
          if (s1_en_i && s1_short) begin
            slot_d = SLOT_ONE; phase_d = PH_DATA; tenbit_d = 1'b0; fin_match = 1'b1;
          end else if (s1_en_i && s1_hdr && !byte_i[0]) begin
            phase_d = PH_LOW; tenbit_d = 1'b0;
          end else if (s1_en_i && s1_hdr && byte_i[0] && tenbit_q) begin
            slot_d = SLOT_ONE; phase_d = PH_DATA; fin_match = 1'b1;
          end else if (s2_en_i && s2_eq) begin
            slot_d = SLOT_TWO; phase_d = PH_DATA; tenbit_d = 1'b0; fin_match = 1'b1;
          end else begin
            ack_d = 1'b0; phase_d = PH_IDLE; tenbit_d = 1'b0; fin_nack = 1'b1;
          end
        end
        PH_LOW: begin
          vld_d = 1'b1;
          if (s1_en_i && s1_low) begin
            ack_d = 1'b1; slot_d = SLOT_ONE; phase_d = PH_DATA; tenbit_d = 1'b1; fin_match = 1'b1;
          end else begin
            ack_d = 1'b0; phase_d = PH_IDLE; fin_nack = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase_q  <= PH_IDLE;
      tenbit_q <= 1'b0;
      vld_q    <= 1'b0;
      ack_q    <= 1'b0;
      slot_q   <= '0;
      dir_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      tenbit_q <= tenbit_d;
      vld_q    <= vld_d;
      ack_q    <= ack_d;
      slot_q   <= slot_d;
      dir_q    <= dir_d;
    end
  end

  wake_ctl u_wake (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .lp_active_i  (lp_mode_i && stretch_en_i),
    .start_i      (ev_start_i && !ev_stop_i),
    .stop_i       (ev_stop_i),
    .match_i      (fin_match),
    .nack_i       (fin_nack),
    .clk_ready_i  (clk_ready_i),
    .host_awake_i (host_awake_i),
    .clk_req_o    (clk_req_o),
    .wake_req_o   (wake_req_o),
    .scl_hold_o   (scl_hold_o)
  );

  assign dec_vld_o = vld_q;
  assign dec_ack_o = ack_q;
  assign hit_o     = |slot_q;
  assign slot_o    = slot_q;
  assign dir_rd_o  = dir_q;

  p_slot_onehot_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(slot_q));
  p_hit_on_ack_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(hit_o) |-> vld_q && ack_q);
  p_nack_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    vld_q && !ack_q |-> !hit_o);
  p_dec_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    vld_q |-> $past(byte_vld_i));
  p_clear_on_event_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    ev_stop_i || ev_start_i |=> slot_q == '0);
endmodule

// File: tb/test_dual_addr_matcher.sv
module test_dual_addr_matcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       ev_start, ev_stop, byte_vld;
  logic [7:0] byte_d;
  logic       s1_en, s1_wide, s2_en, lp_mode, stretch_en, clk_ready, host_awake;
  logic [9:0] s1_addr;
  logic [6:0] s2_addr;
  logic [1:0] s2_mask;
  logic       dec_vld, dec_ack, hit, dir_rd, clk_req, wake_req, scl_hold;
  logic [1:0] slot;

  dual_addr_matcher i_dual_addr_matcher (
    .clk(clk), .rst_n(rst_n), .ev_start_i(ev_start), .ev_stop_i(ev_stop),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .s1_en_i(s1_en), .s1_wide_i(s1_wide),
    .s1_addr_i(s1_addr), .s2_en_i(s2_en), .s2_addr_i(s2_addr), .s2_mask_i(s2_mask),
    .lp_mode_i(lp_mode), .stretch_en_i(stretch_en), .clk_ready_i(clk_ready),
    .host_awake_i(host_awake), .dec_vld_o(dec_vld), .dec_ack_o(dec_ack), .hit_o(hit),
    .slot_o(slot), .dir_rd_o(dir_rd), .clk_req_o(clk_req), .wake_req_o(wake_req),
    .scl_hold_o(scl_hold)
  );

  int checks = 0;
  int fails  = 0;
  logic finished = 1'b0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
  endtask
  task automatic do_stop();
    ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
  endtask
  task automatic do_byte(input logic [7:0] b);
    byte_d = b; byte_vld = 1'b1; @(negedge clk); byte_vld = 1'b0;
  endtask

  typedef struct packed {
    logic       s1en;
    logic [6:0] a1;
    logic       s2en;
    logic [6:0] a2;
    logic [1:0] msk;
    logic [7:0] b;
    logic       ack;
    logic [1:0] oh;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'h50, 1'b0, 7'h00, 2'd0, 8'hA0, 1'b1, 2'b01},  // R1 write
    '{1'b1, 7'h50, 1'b0, 7'h00, 2'd0, 8'hA1, 1'b1, 2'b01},  // R1 read
    '{1'b0, 7'h00, 1'b1, 7'h33, 2'd0, 8'h66, 1'b1, 2'b10},  // R2 exact
    '{1'b0, 7'h00, 1'b1, 7'h33, 2'd2, 8'h60, 1'b1, 2'b10},  // R2 two low bits masked
    '{1'b0, 7'h00, 1'b1, 7'h33, 2'd2, 8'h6E, 1'b0, 2'b00},  // R2 unmasked bit differs
    '{1'b0, 7'h00, 1'b1, 7'h30, 2'd3, 8'h6F, 1'b1, 2'b10},  // R2 three bits masked
    '{1'b0, 7'h00, 1'b1, 7'h30, 2'd1, 8'h64, 1'b0, 2'b00},  // R2 bit 1 not masked
    '{1'b1, 7'h21, 1'b1, 7'h21, 2'd0, 8'h42, 1'b1, 2'b01},  // R4 both, slot 1 wins
    '{1'b1, 7'h21, 1'b1, 7'h22, 2'd0, 8'h44, 1'b1, 2'b10},  // R4 slot 2 only
    '{1'b0, 7'h50, 1'b0, 7'h50, 2'd0, 8'hA0, 1'b0, 2'b00},  // R3 disabled
    '{1'b1, 7'h51, 1'b0, 7'h00, 2'd0, 8'hA0, 1'b0, 2'b00}   // R3 mismatch
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    ev_start = 0; ev_stop = 0; byte_vld = 0; byte_d = 0;
    s1_en = 0; s1_wide = 0; s1_addr = 0; s2_en = 0; s2_addr = 0; s2_mask = 0;
    lp_mode = 0; stretch_en = 0; clk_ready = 0; host_awake = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("reset dec_vld", 16'(dec_vld), 16'h0);
    chk("reset hit/slot", {hit, slot}, 16'h0);
    chk("reset wake path", {clk_req, wake_req, scl_hold}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      s1_en = VEC[i].s1en; s1_wide = 1'b0; s1_addr = {3'b000, VEC[i].a1};
      s2_en = VEC[i].s2en; s2_addr = VEC[i].a2; s2_mask = VEC[i].msk;
      do_start();
      do_byte(VEC[i].b);
      chk($sformatf("R1-R4 vec %0d dec", i), {dec_vld, dec_ack}, {1'b1, VEC[i].ack});
      chk($sformatf("R1-R4 vec %0d slot", i), {hit, slot}, {|VEC[i].oh, VEC[i].oh});
      if (VEC[i].ack) chk($sformatf("R1 vec %0d dir", i), 16'(dir_rd), 16'(VEC[i].b[0]));
      do_stop();
    end

    // R7: data bytes after a match give no decision
    s1_en = 1; s1_addr = 10'h050; s2_en = 0;
    do_start(); do_byte(8'hA0);
    do_byte(8'hA2);
    chk("R7 data byte no decision", {dec_vld, hit, slot}, {1'b0, 1'b1, 2'b01});
    do_stop();
    chk("R12 stop clears hit", {hit, slot}, 16'h0);
    // R7: bytes after a refusal ignored
    do_start(); do_byte(8'hB0); do_byte(8'hA0);
    chk("R7 after refusal no decision", {dec_vld, hit}, 16'h0);
    do_stop();

    // R5/R6 ten-bit, address 0x2A5
    s1_wide = 1; s1_addr = 10'h2A5;
    do_start(); do_byte(8'hF4);
    chk("R5 header ack no hit", {dec_vld, dec_ack, hit}, 16'b110);
    do_byte(8'hA5);
    chk("R5 low byte match", {dec_vld, dec_ack, hit, slot, dir_rd}, {3'b111, 2'b01, 1'b0});
    do_start();
    chk("R12 start clears hit", {hit, slot}, 16'h0);
    do_byte(8'hF5);
    chk("R6 read header after write", {dec_vld, dec_ack, hit, slot, dir_rd}, {3'b111, 2'b01, 1'b1});
    do_stop();
    do_start(); do_byte(8'hF5);
    chk("R6 read header after stop refused", {dec_vld, dec_ack, hit}, 16'b100);
    do_stop();
    do_start(); do_byte(8'hF4); do_byte(8'hA4);
    chk("R5 wrong low byte", {dec_vld, dec_ack, hit}, 16'b100);
    do_stop();

    // R8/R9 low power match
    s1_wide = 0; s1_addr = 10'h050; lp_mode = 1; stretch_en = 1; clk_ready = 0;
    do_start();
    chk("R8 clk request after start", {clk_req, scl_hold}, 16'b11);
    clk_ready = 1; #1;
    chk("R8 hold released on ready", 16'(scl_hold), 16'h0);
    @(negedge clk);
    do_byte(8'hA0);
    chk("R9 wake on match", {dec_ack, wake_req, scl_hold}, 16'b111);
    @(negedge clk);
    chk("R9 still stretched", {wake_req, scl_hold}, 16'b11);
    host_awake = 1; @(negedge clk); host_awake = 0;
    chk("R9 released after awake", {wake_req, clk_req, scl_hold}, 16'h0);
    do_stop();

    // R10 low power mismatch
    do_start();
    chk("R10 clk request set", 16'(clk_req), 16'h1);
    do_byte(8'hB0);
    chk("R10 mismatch", {dec_vld, dec_ack, wake_req, clk_req}, 16'b1000);
    do_stop();

    // R11 no stretching
    stretch_en = 0;
    do_start();
    chk("R11 no clk request", 16'(clk_req), 16'h0);
    do_byte(8'hA0);
    chk("R11 match without wake", {dec_ack, wake_req, clk_req, scl_hold}, 16'b1000);
    do_stop();

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule